// File: doc/BRIEF.md
# Exception Escalation Controller

This block follows the delivery of processor exceptions and decides what happens when a second exception arrives while the handler for an earlier one is still being entered. Each incoming vector is sorted into one of three classes: benign, contributory or page fault. While a handler is being entered, the class of the pending exception and the class of the new one are combined under an asymmetric rule. The result is one of three outcomes. The new exception may simply replace the pending one. It may be escalated to a double fault. Or, if a double-fault handler is already being entered, the processor halts for good.

The surrounding core strobes `raise_i` with a vector whenever an exception is detected. It strobes `entry_done_i` once the current handler has been entered successfully. The core reads back which vector to deliver, whether an error code goes with it, and whether the processor has halted. Stack pushes, descriptor fetches and the ordering of simultaneous exceptions stay in the core.

Top module: `exc_escalator`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it goes high, all of these are 0: `dlv_pend_o`, `dlv_vec_o`, `err_valid_o`, `err_code_o` and `halt_o`.
- R2: With no delivery pending and no halt, a raise makes the outputs change one clock later. `dlv_pend_o` becomes 1, `dlv_vec_o` takes the raised vector unchanged, and `err_valid_o` is 0.
- R3: Vectors 1, 2, 3, 4, 5, 6, 7 and 16 are benign. Vectors 0, 9, 10, 11, 12 and 13 are contributory. Vector 14 is the page-fault class. Every other value, vector 8 included, counts as benign.
- R4: A contributory exception is pending and a contributory exception is raised. One clock later a double fault is being delivered.
- R5: A page fault is pending and a contributory exception or a page fault is raised. One clock later a double fault is being delivered.
- R6: Any other pairing is handled in series. This covers a benign exception on either side, and a contributory exception pending when a page fault is raised. One clock later `dlv_vec_o` shows the new vector, `err_valid_o` is 0, and the new exception's class becomes the pending class.
- R7: While a double fault is being delivered, `dlv_vec_o` is 8, `err_valid_o` is 1 and `err_code_o` is 0.
- R8: A raise while a double fault is being delivered sets `halt_o` one clock later. After that, `halt_o` stays 1 and `dlv_pend_o` and `err_valid_o` stay 0 until reset, whatever arrives on `raise_i` or `entry_done_i`.
- R9: `entry_done_i` while a delivery is pending clears `dlv_pend_o` and `err_valid_o` one clock later. If a raise comes in the same cycle, the raise takes priority. `entry_done_i` has no effect when nothing is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| raise_i | input | 1 | Exception detected this cycle |
| raise_vec_i | input | 8 | Vector of the detected exception |
| entry_done_i | input | 1 | Current handler has been entered |
| dlv_pend_o | output | 1 | A delivery is in progress |
| dlv_vec_o | output | 8 | Vector to deliver |
| err_valid_o | output | 1 | An error code accompanies the delivery |
| err_code_o | output | 32 | Error code value |
| halt_o | output | 1 | Processor has halted; only reset clears it |

## Verification
Directed sequences pair one vector from each class with a second raise from each class. This covers the whole three-by-three outcome matrix. It separates the asymmetric cells, such as contributory followed by page fault versus page fault followed by contributory, and it separates the unlisted vectors from the listed ones. Further sequences run a double fault into a third raise, then apply raises and handler-entry strobes while halted. These show that the halt is absorbing and that the raise wins over `entry_done_i` in the same cycle. Random traffic mixes raises, entry strobes and occasional resets across the whole vector range. This drives long chains of serial replacement, where the pending class has to follow the latest exception rather than the first.

// File: rtl/exc_esc_pkg.sv
// Shared types for the exception escalation controller.
// Assumes: the class encoding is internal and never leaves the block.
package exc_esc_pkg;
    typedef enum logic [1:0] {
        CLS_BENIGN  = 2'd0,
        CLS_CONTRIB = 2'd1,
        CLS_PAGE    = 2'd2
    } exc_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DLV    = 2'd1,
        ST_DLV_DF = 2'd2,
        ST_HALT   = 2'd3
    } esc_state_e;
endpackage

// File: rtl/exc_classifier.sv
// Sorts an exception vector into benign, contributory or page-fault class.
// Assumes: any value not named as contributory or page fault is benign.
module exc_classifier
    import exc_esc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic [VEC_W-1:0] vec_i,
    output exc_cls_e         cls_o
);
    // Pure decode of the vector value into its class.
    always_comb begin
        if (vec_i == VEC_W'(14))
            cls_o = CLS_PAGE;
        else if (vec_i inside {VEC_W'(0), VEC_W'(9), VEC_W'(10),
                               VEC_W'(11), VEC_W'(12), VEC_W'(13)})
            cls_o = CLS_CONTRIB;
        else
            cls_o = CLS_BENIGN;
    end
endmodule

// File: rtl/exc_pair_rule.sv
// Decides whether a second exception on top of a pending one escalates.
// Assumes: caller only uses the result while a non-double delivery is pending.
module exc_pair_rule
    import exc_esc_pkg::*;
(
    input  exc_cls_e first_i,
    input  exc_cls_e second_i,
    output logic     escalate_o
);
    // Asymmetric matrix: contrib+contrib, page+contrib, page+page escalate.
    always_comb begin
        unique case (first_i)
            CLS_CONTRIB: escalate_o = (second_i == CLS_CONTRIB);
            CLS_PAGE:    escalate_o = (second_i != CLS_BENIGN);
            default:     escalate_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/exc_escalator.sv
// Exception escalation controller: tracks handler entry, escalates a second
// exception to a double fault, and halts on an exception during double-fault
// entry. Assumes one raise at most per cycle; the core orders simultaneous ones.
module exc_escalator
    import exc_esc_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int ERR_W  = 32,
    parameter int DF_VEC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raise_i,
    input  logic [VEC_W-1:0] raise_vec_i,
    input  logic             entry_done_i,
    output logic             dlv_pend_o,
    output logic [VEC_W-1:0] dlv_vec_o,
    output logic             err_valid_o,
    output logic [ERR_W-1:0] err_code_o,
    output logic             halt_o
);
    localparam logic [VEC_W-1:0] DF_VEC_L = VEC_W'(DF_VEC);

    esc_state_e       state_q;
    exc_cls_e         first_q;
    exc_cls_e         new_cls;
    logic             escalate;
    logic [VEC_W-1:0] vec_q;

    exc_classifier #(.VEC_W(VEC_W)) u_cls (
        .vec_i (raise_vec_i),
        .cls_o (new_cls)
    );

    exc_pair_rule u_rule (
        .first_i    (first_q),
        .second_i   (new_cls),
        .escalate_o (escalate)
    );

    // State, pending class and delivered vector update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            first_q <= CLS_BENIGN;
            vec_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (raise_i) begin
                        state_q <= ST_DLV;
                        first_q <= new_cls;
                        vec_q   <= raise_vec_i;
                    end
                end
                ST_DLV: begin
                    if (raise_i && escalate) begin
                        state_q <= ST_DLV_DF;
                        vec_q   <= DF_VEC_L;
                    end else if (raise_i) begin
                        first_q <= new_cls;
                        vec_q   <= raise_vec_i;
                    end else if (entry_done_i) begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_DLV_DF: begin
                    if (raise_i) begin
                        state_q <= ST_HALT;
                        vec_q   <= '0;
                    end else if (entry_done_i) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_HALT;
            endcase
        end
    end

    // Output decode from the registered state.
    always_comb begin
        dlv_pend_o  = (state_q == ST_DLV) || (state_q == ST_DLV_DF);
        dlv_vec_o   = vec_q;
        err_valid_o = (state_q == ST_DLV_DF);
        err_code_o  = '0;
        halt_o      = (state_q == ST_HALT);
    end
endmodule

// File: rtl/exc_escalator_chk.sv
// Port-level properties of the escalation controller, bound to every instance.
module exc_escalator_chk #(
    parameter int VEC_W  = 8,
    parameter int ERR_W  = 32,
    parameter int DF_VEC = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             raise_i,
    input logic [VEC_W-1:0] raise_vec_i,
    input logic             entry_done_i,
    input logic             dlv_pend_o,
    input logic [VEC_W-1:0] dlv_vec_o,
    input logic             err_valid_o,
    input logic [ERR_W-1:0] err_code_o,
    input logic             halt_o
);
    // R2
    idle_raise_delivers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dlv_pend_o && !halt_o && raise_i) |=>
            (dlv_pend_o && !err_valid_o && dlv_vec_o == $past(raise_vec_i)));

    // R7
    df_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid_o |-> (dlv_pend_o && dlv_vec_o == VEC_W'(DF_VEC) && err_code_o == '0));

    // R8
    df_raise_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid_o && raise_i) |=> halt_o);

    // R8
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> (halt_o && !dlv_pend_o && !err_valid_o));

    // R9
    entry_done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_pend_o && entry_done_i && !raise_i) |=> (!dlv_pend_o && !err_valid_o && !halt_o));
endmodule

bind exc_escalator exc_escalator_chk #(
    .VEC_W(VEC_W), .ERR_W(ERR_W), .DF_VEC(DF_VEC)
) u_chk (.*);

// File: tb/exc_escalator_test.sv
module exc_escalator_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raise_i = 1'b0;
    logic [7:0]  raise_vec_i = '0;
    logic        entry_done_i = 1'b0;
    logic        dlv_pend_o;
    logic [7:0]  dlv_vec_o;
    logic        err_valid_o;
    logic [31:0] err_code_o;
    logic        halt_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    // reference model: 0 idle, 1 delivering, 2 double, 3 halted
    int       m_st = 0;
    int       m_cls = 0;
    logic [7:0] m_vec = '0;
    string    m_tag = "R1";

    exc_escalator uut (.*);

    always #5 clk = ~clk;

    // 0 benign, 1 contributory, 2 page fault (R3)
    function automatic int cls_of(input logic [7:0] v);
        case (v)
            8'd14: return 2;
            8'd0, 8'd9, 8'd10, 8'd11, 8'd12, 8'd13: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic bit esc_of(input int a, input int b);
        if (a == 1 && b == 1) return 1;
        if (a == 2 && b != 0) return 1;
        return 0;
    endfunction

    task automatic model_step(input bit rst, input bit r, input logic [7:0] v, input bit d);
        if (!rst) begin
            m_st = 0; m_cls = 0; m_vec = 0; m_tag = "R1";
            return;
        end
        case (m_st)
            0: if (r) begin m_st = 1; m_cls = cls_of(v); m_vec = v; m_tag = "R2/R3"; end
               else if (d) m_tag = "R9";
            1: if (r) begin
                   if (esc_of(m_cls, cls_of(v))) begin
                       m_st = 2; m_vec = 8'd8;
                       m_tag = (m_cls == 2) ? "R5/R7" : "R4/R7";
                   end else begin
                       m_cls = cls_of(v); m_vec = v; m_tag = "R6";
                   end
               end else if (d) begin m_st = 0; m_tag = "R9"; end
            2: if (r) begin m_st = 3; m_vec = 0; m_tag = "R8"; end
               else if (d) begin m_st = 0; m_tag = "R9"; end
            default: m_tag = "R8";
        endcase
    endtask

    task automatic check_out();
        logic e_pend, e_errv, e_halt;
        logic [7:0] e_vec;
        e_pend = (m_st == 1 || m_st == 2);
        e_errv = (m_st == 2);
        e_halt = (m_st == 3);
        e_vec  = m_vec;
        n_chk++;
        if (dlv_pend_o !== e_pend || err_valid_o !== e_errv || halt_o !== e_halt ||
            dlv_vec_o !== e_vec || err_code_o !== 32'd0) begin
            n_bad++;
            $display("FAIL %s: got pend=%b vec=%0d errv=%b err=%0h halt=%b, expected pend=%b vec=%0d errv=%b err=0 halt=%b",
                     m_tag, dlv_pend_o, dlv_vec_o, err_valid_o, err_code_o, halt_o,
                     e_pend, e_vec, e_errv, e_halt);
        end
    endtask

    // one cycle: drive at negedge, model, then check at the following negedge
    task automatic step(input bit rst, input bit r, input logic [7:0] v, input bit d);
        rst_n = rst; raise_i = r; raise_vec_i = v; entry_done_i = d;
        model_step(rst, r, v, d);
        @(negedge clk);
        check_out();
    endtask

    initial begin
        logic [7:0] reps [3];
        reps[0] = 8'd3; reps[1] = 8'd13; reps[2] = 8'd14;
        @(negedge clk);
        // R1 reset state
        step(0, 1, 8'd14, 1);
        step(0, 0, 8'd0, 0);
        step(1, 0, 8'd0, 0);
        // R9 entry_done in idle ignored
        step(1, 0, 8'd0, 1);
        // R4 R5 R6 full matrix of first/second classes
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 3; b++) begin
                step(0, 0, 8'd0, 0);
                step(1, 1, reps[a], 0);
                step(1, 1, reps[b], 0);
                step(1, 0, 8'd0, 1);
            end
        end
        // R3 unlisted vectors 8 and 200 act benign after contributory
        step(0, 0, 0, 0);
        step(1, 1, 8'd11, 0);
        step(1, 1, 8'd8, 0);
        step(1, 1, 8'd200, 0);
        // R6 class replaced: benign now pending, contributory does not escalate
        step(1, 1, 8'd0, 0);
        step(1, 1, 8'd12, 0);
        // R7 then R8 halt, raise beats entry_done
        step(1, 1, 8'd10, 1);
        step(1, 1, 8'd14, 0);
        step(1, 1, 8'd1, 1);
        step(1, 0, 8'd0, 1);
        step(1, 1, 8'd0, 0);
        // R9 raise wins over entry_done while delivering
        step(0, 0, 0, 0);
        step(1, 1, 8'd14, 0);
        step(1, 1, 8'd0, 1);
        step(1, 0, 8'd0, 1);
        // random traffic, fixed seed
        void'($urandom(32'd4242));
        for (int i = 0; i < 3000; i++) begin
            bit rs, r, d;
            logic [7:0] v;
            rs = ($urandom_range(0, 99) >= 3);
            r  = ($urandom_range(0, 99) < 45);
            d  = ($urandom_range(0, 99) < 35);
            v  = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'($urandom_range(0, 17));
            step(rs, r, v, d);
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: got no finish, expected finish before 200000 cycles");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule